// File: doc/BRIEF.md
# Hybrid Static and History Branch Direction Predictor

This block answers "taken or not taken?" for a branch, in the same cycle the question is asked. It keeps a small direct-mapped table of entries, selected by the low bits of the branch address. Each entry remembers the most recent outcomes of the branches that map to it. Once an entry has seen enough outcomes, it predicts by majority vote over that history.

While an entry is still short of history, the answer comes from a fixed rule keyed on a two-bit branch-kind code supplied with the request. The history depth `HIST_N` can be set from 0 to 5. A depth of zero removes the history table and leaves only the fixed rule.

A fetch stage drives the predict port with the branch address and kind. The execute stage reports resolved outcomes on the update port. The block does not predict branch targets.

Top module: `hybrid_branch_predictor`

## Requirements
- R1: After reset is asserted (active-low, asynchronous), every entry has an empty history, so every prediction follows the fixed rule of R2.
- R2: The fixed rule decodes `pred_kind_i` as follows: 2'b00 unconditional → taken; 2'b01 conditional → not taken; 2'b10 loop → taken; 2'b11 call/return → taken.
- R3: An entry keeps using the fixed rule until it has recorded `HIST_N` outcomes since the last reset.
- R4: Once an entry holds `HIST_N` outcomes, the prediction is taken exactly when more than half of them were taken, whatever the kind code. For `HIST_N`=3 that means two or more of the three.
- R5: With an even `HIST_N`, a history that is exactly half taken predicts not taken.
- R6: Each accepted update appends the actual outcome to the selected entry and discards the oldest one, so only the last `HIST_N` outcomes are kept. The count of recorded outcomes saturates at `HIST_N`.
- R7: When a predict and an update select the same entry in one cycle, the prediction uses the history as it was before that update.
- R8: The entry is selected by the low `IDX_W` bits of the address. Higher address bits do not affect which entry is used, on either port.
- R9: With `HIST_N`=0, every prediction follows the fixed rule, and updates have no effect.
- R10: An update presented with `upd_valid_i` low changes no entry.
- R11: `pred_taken_o` is a combinational function of the predict inputs and the stored state. No clock edge is needed between the request and the answer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pred_addr_i | input | ADDR_W | Address of the branch being predicted |
| pred_kind_i | input | 2 | Branch-kind code used by the fixed rule |
| pred_taken_o | output | 1 | Predicted direction, 1 = taken |
| upd_valid_i | input | 1 | Update strobe |
| upd_addr_i | input | ADDR_W | Address of the resolved branch |
| upd_taken_i | input | 1 | Actual outcome, 1 = taken |

## Verification
The bench drives three copies of the block from the same stimulus, each with an 8-entry table: `HIST_N`=3, `HIST_N`=4 and `HIST_N`=0.

- The depth-3 copy covers the ordinary two-of-three vote and the hand-over from the fixed rule.
- The depth-4 copy reaches the half-taken tie of R5 and a longer fallback period.
- The depth-0 copy shows that outcomes are ignored entirely.

Addresses that share low bits but differ in high bits exercise aliasing. Update and predict are often aimed at the same entry in the same cycle, to pin down the old-history rule.

// File: rtl/bp_pkg.sv
package bp_pkg;

  typedef enum logic [1:0] {
    BR_UNCOND  = 2'd0,
    BR_COND    = 2'd1,
    BR_LOOP    = 2'd2,
    BR_CALLRET = 2'd3
  } br_kind_e;

  localparam int unsigned MAX_HIST = 5;

endpackage

// File: rtl/bp_static_rule.sv
module bp_static_rule
  import bp_pkg::*;
(
  input  logic [1:0] kind_i,
  output logic       taken_o
);

  br_kind_e kind;

  assign kind = br_kind_e'(kind_i);

  always_comb begin
    unique case (kind)
      BR_COND:    taken_o = 1'b0;
      BR_UNCOND:  taken_o = 1'b1;
      BR_LOOP:    taken_o = 1'b1;
      BR_CALLRET: taken_o = 1'b1;
      default:    taken_o = 1'b1;
    endcase
  end

endmodule

// File: rtl/bp_vote.sv
module bp_vote #(
  parameter int unsigned N = 3
) (
  input  logic [N-1:0] hist_i,
  output logic         taken_o
);

  localparam int unsigned SUM_W = $clog2(N + 1) + 1;

  logic [SUM_W-1:0] ones;

  always_comb begin
    ones = '0;
    for (int b = 0; b < int'(N); b++) begin
      ones = ones + SUM_W'(hist_i[b]);
    end
  end

  // strict majority: a tie on even N loses
  assign taken_o = ({ones, 1'b0} > (SUM_W + 1)'(N));

endmodule

// File: rtl/bp_hist_entry.sv
module bp_hist_entry #(
  parameter int unsigned N = 3,
  localparam int unsigned CNT_W = $clog2(N + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             taken_i,
  output logic [N-1:0]     hist_o,
  output logic [CNT_W-1:0] cnt_o
);

  logic [N-1:0]     hist_q;
  logic [CNT_W-1:0] cnt_q;
  logic [N:0]       shifted;

  assign shifted = {hist_q, taken_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q <= '0;
      cnt_q  <= '0;
    end else if (wr_i) begin
      hist_q <= shifted[N-1:0];
      if (cnt_q != CNT_W'(N)) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign hist_o = hist_q;
  assign cnt_o  = cnt_q;

  a_r6_cnt_sat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(cnt_q) <= int'(N));

  a_r6_cnt_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && int'(cnt_q) < int'(N)) |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));

  a_r6_newest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> hist_q[0] == $past(taken_i));

  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> ($stable(hist_q) && $stable(cnt_q)));

  if (N >= 2) begin : g_age
    a_r6_age: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_i |=> hist_q[N-1:1] == $past(hist_q[N-2:0]));
  end

endmodule

// File: rtl/hybrid_branch_predictor.sv
module hybrid_branch_predictor
  import bp_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 4,
  parameter int unsigned HIST_N = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] pred_addr_i,
  input  logic [1:0]        pred_kind_i,
  output logic              pred_taken_o,
  input  logic              upd_valid_i,
  input  logic [ADDR_W-1:0] upd_addr_i,
  input  logic              upd_taken_i
);

  localparam int unsigned ENTRIES = 1 << IDX_W;

  logic static_taken;

  bp_static_rule u_static (
    .kind_i  (pred_kind_i),
    .taken_o (static_taken)
  );

  if (HIST_N == 0) begin : g_static_only
    logic unused_inputs;
    assign unused_inputs = ^{clk_i, rst_ni, pred_addr_i, upd_valid_i, upd_addr_i, upd_taken_i};
    assign pred_taken_o  = static_taken;
  end else begin : g_history
    localparam int unsigned CNT_W = $clog2(HIST_N + 1);

    logic [IDX_W-1:0]  pred_idx;
    logic [IDX_W-1:0]  upd_idx;
    logic [HIST_N-1:0] hist_a [ENTRIES];
    logic [CNT_W-1:0]  cnt_a  [ENTRIES];
    logic [HIST_N-1:0] sel_hist;
    logic [CNT_W-1:0]  sel_cnt;
    logic              vote_taken;
    logic              unused_hi;

    assign pred_idx  = pred_addr_i[IDX_W-1:0];
    assign upd_idx   = upd_addr_i[IDX_W-1:0];
    assign unused_hi = ^{pred_addr_i[ADDR_W-1:IDX_W], upd_addr_i[ADDR_W-1:IDX_W]};

    for (genvar e = 0; e < int'(ENTRIES); e++) begin : g_entry
      bp_hist_entry #(.N(HIST_N)) u_entry (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .wr_i    (upd_valid_i && (upd_idx == IDX_W'(e))),
        .taken_i (upd_taken_i),
        .hist_o  (hist_a[e]),
        .cnt_o   (cnt_a[e])
      );
    end

    // read side sees registered state only: same-cycle update is not forwarded
    assign sel_hist = hist_a[pred_idx];
    assign sel_cnt  = cnt_a[pred_idx];

    bp_vote #(.N(HIST_N)) u_vote (
      .hist_i  (sel_hist),
      .taken_o (vote_taken)
    );

    assign pred_taken_o = (sel_cnt == CNT_W'(HIST_N)) ? vote_taken : static_taken;

    a_r3_fallback: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (int'(sel_cnt) < int'(HIST_N)) |-> (pred_taken_o == static_taken));

    a_r7_old_hist: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (upd_valid_i && upd_idx == pred_idx) |=> $past(sel_cnt) == sel_cnt
        || int'(sel_cnt) == int'($past(sel_cnt)) + 1 || $past(pred_idx) != pred_idx);
  end

endmodule

// File: tb/hybrid_branch_predictor_test.sv
module hybrid_branch_predictor_test;

  localparam int CLK_P  = 10;
  localparam int ADDR_W = 32;
  localparam int IDX_W  = 3;
  localparam int NENT   = 1 << IDX_W;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic [ADDR_W-1:0] pred_addr = '0;
  logic [1:0]        pred_kind = '0;
  logic              upd_valid = 1'b0;
  logic [ADDR_W-1:0] upd_addr = '0;
  logic              upd_taken = 1'b0;
  logic              p3, p4, p0;

  int vectors = 0;
  int fails   = 0;
  int cycles  = 0;
  bit done    = 1'b0;

  bit hq [3][NENT][$];

  always #(CLK_P/2) clk = ~clk;

  hybrid_branch_predictor #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .HIST_N(3)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .pred_addr_i(pred_addr), .pred_kind_i(pred_kind),
    .pred_taken_o(p3), .upd_valid_i(upd_valid), .upd_addr_i(upd_addr), .upd_taken_i(upd_taken));

  hybrid_branch_predictor #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .HIST_N(4)) uut_even (
    .clk_i(clk), .rst_ni(rst_ni), .pred_addr_i(pred_addr), .pred_kind_i(pred_kind),
    .pred_taken_o(p4), .upd_valid_i(upd_valid), .upd_addr_i(upd_addr), .upd_taken_i(upd_taken));

  hybrid_branch_predictor #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .HIST_N(0)) uut_static (
    .clk_i(clk), .rst_ni(rst_ni), .pred_addr_i(pred_addr), .pred_kind_i(pred_kind),
    .pred_taken_o(p0), .upd_valid_i(upd_valid), .upd_addr_i(upd_addr), .upd_taken_i(upd_taken));

  function automatic int depth(int k);
    return (k == 0) ? 3 : (k == 1) ? 4 : 0;
  endfunction

  function automatic bit expect_pred(int k, int e, int kind);
    int n = depth(k);
    int ones = 0;
    if (n == 0 || hq[k][e].size() < n) return (kind != 1);
    foreach (hq[k][e][j]) ones += hq[k][e][j];
    return (2 * ones > n);
  endfunction

  task automatic model_clear();
    for (int k = 0; k < 3; k++)
      for (int e = 0; e < NENT; e++) hq[k][e].delete();
  endtask

  task automatic check(string req, string who, bit act, bit exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s t=%0t actual=%0b expected=%0b", req, who, $time, act, exp);
    end
  endtask

  // one cycle: drive at negedge, compare mid-low phase, advance model at posedge
  task automatic step(logic [ADDR_W-1:0] pa, int kind, bit uv, logic [ADDR_W-1:0] ua,
                      bit ut, string req);
    int pe = int'(pa[IDX_W-1:0]);
    int ue = int'(ua[IDX_W-1:0]);
    @(negedge clk);
    pred_addr = pa; pred_kind = 2'(kind);
    upd_valid = uv; upd_addr = ua; upd_taken = ut;
    #(CLK_P/4);
    check(req, "n3", p3, expect_pred(0, pe, kind));
    check(req, "n4", p4, expect_pred(1, pe, kind));
    check((req == "R1" || req == "R2") ? req : "R9", "n0", p0, expect_pred(2, pe, kind));
    @(posedge clk);
    if (uv) begin
      for (int k = 0; k < 3; k++) begin
        if (depth(k) > 0) begin
          hq[k][ue].push_back(ut);
          if (hq[k][ue].size() > depth(k)) void'(hq[k][ue].pop_front());
        end
      end
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    model_clear();
    upd_valid = 1'b0;
    #(CLK_P/4);
    rst_ni = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    do_reset();

    // R1 R2: fresh table, every kind on several entries
    for (int a = 0; a < NENT; a++)
      for (int kd = 0; kd < 4; kd++)
        step(32'(a) | 32'h4000_0000, kd, 1'b0, '0, 1'b0, (kd == 1) ? "R2" : "R1");

    // R3: entry 5 fills up, conditional kind shows the hand-over
    for (int i = 0; i < 5; i++) step(32'h5, 1, 1'b1, 32'h5, 1'b1, "R3");
    step(32'h5, 1, 1'b0, '0, 1'b0, "R4");

    // R6 R4: oldest outcomes leave the window
    for (int i = 0; i < 4; i++) step(32'h5, 0, 1'b1, 32'h5, 1'b0, "R6");
    step(32'h5, 0, 1'b0, '0, 1'b0, "R4");
    step(32'h5, 1, 1'b1, 32'h5, 1'b1, "R6");
    step(32'h5, 1, 1'b1, 32'h5, 1'b1, "R6");
    step(32'h5, 1, 1'b0, '0, 1'b0, "R4");

    // R5: tie on depth 4 with an unconditional kind (fixed rule would say taken)
    step(32'h2, 0, 1'b1, 32'h2, 1'b1, "R5");
    step(32'h2, 0, 1'b1, 32'h2, 1'b0, "R5");
    step(32'h2, 0, 1'b1, 32'h2, 1'b1, "R5");
    step(32'h2, 0, 1'b1, 32'h2, 1'b0, "R5");
    step(32'h2, 0, 1'b0, '0, 1'b0, "R5");
    step(32'h2, 3, 1'b0, '0, 1'b0, "R5");

    // R7: same-entry update and predict in one cycle
    for (int i = 0; i < 6; i++) step(32'h7, 1, 1'b1, 32'h7, i[0], "R7");
    step(32'h7, 1, 1'b1, 32'h7, 1'b1, "R7");
    step(32'h7, 1, 1'b0, '0, 1'b0, "R7");

    // R8: aliasing through high address bits
    for (int i = 0; i < 4; i++) step(32'hABC0_0003, 2, 1'b1, 32'h1230_0003 + 32'(i << 8), 1'b0, "R8");
    step(32'hFFFF_FFF3 & 32'hFFFF_FFFB, 2, 1'b0, '0, 1'b0, "R8");
    step(32'h0000_0013, 0, 1'b0, '0, 1'b0, "R8");

    // R10: writes with strobe low
    for (int i = 0; i < 5; i++) step(32'h6, 1, 1'b0, 32'h6, 1'b1, "R10");
    step(32'h6, 1, 1'b0, '0, 1'b0, "R10");

    // R11 R4 R9: long mixed traffic
    for (int i = 0; i < 3000; i++) begin
      logic [ADDR_W-1:0] ra = $urandom();
      logic [ADDR_W-1:0] ua = (i % 3 == 0) ? ra : $urandom();
      step(ra, int'($urandom() % 4), bit'($urandom() % 4 != 0), ua,
           bit'($urandom() % 3 != 0), (i % 2) ? "R11" : "R4");
    end

    // R1: reset in the middle of activity
    do_reset();
    for (int a = 0; a < NENT; a++) step(32'(a), 1, 1'b0, '0, 1'b0, "R1");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule